// File: doc/BRIEF.md
# Interval Timer Channel (Rate Generator)

This block is one counter channel of an interval timer. Software programs it with byte writes on a small I/O port interface. A select input marks each write as either a control word or a count byte. The control word picks the byte access pattern and the counting mode. The count bytes build a 16-bit reload value. Once the value is complete, the channel divides its timer input by that value and raises a one-cycle interrupt pulse for every period.

The timer input is a clock-enable strobe, `tick_en`, that is sampled on the system clock. Every counting action happens only on a system clock edge where the strobe is high. Only one counting behaviour is built: the rate generator, with binary counting. Each write may be used to set up a periodic interrupt. As an example, a 1193182 Hz tick rate with a 1000 Hz target needs the rounded divisor (1193182 + 500) / 1000 = 1193.

Top module: `pit_channel`

## Requirements
- R1: After reset, `count_o` is 0, `out_o` is 1 and `irq_o` is 0. The channel does not count, and its byte access pattern is low byte then high byte.
- R2: A control word is a write with `wr_ctrl`=1. It is accepted only when all of the following hold:
  - bits [7:6] equal the channel select parameter (default 0);
  - bits [5:4] are not 00;
  - bits [3:1] are 010 or 110;
  - bit 0 is 0.

  Any other control word is ignored and counting goes on unchanged.
- R3: An accepted control word stops the channel. `count_o` then freezes, `out_o` is 1 and `irq_o` stays 0 until a new count has been written.
- R4: An accepted control word resets the byte sequence, so the next count byte is taken as the low byte.
- R5: Access pattern 11 takes the low byte first and the high byte second. Counting starts, or restarts, only after the high byte. On the first tick after the high byte, `count_o` takes the full reload value. A low byte on its own does not disturb a running count.
- R6: Access pattern 01 loads a single byte as the low byte, with the high byte zero. Access pattern 10 loads a single byte as the high byte, with the low byte zero.
- R7: While the channel runs, each tick lowers `count_o` by one. Without a tick, `count_o` does not change.
- R8: `out_o` is 0 exactly while a running count equals 1. The next tick reloads the stored value and returns `out_o` to 1, so a reload value N gives one low period every N ticks.
- R9: `irq_o` is a one-system-cycle pulse. It is high in the cycle right after the tick that brings the count to 1.
- R10: A reload value of 0 acts as 65536. The count wraps from 0 to 65535, and the interrupt comes 65535 ticks after the start.
- R11: Writing control word 0x34 and then the bytes 0xA9 and 0x04 gives a period of 1193 ticks between interrupts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctrl | input | 1 | 1: the write is a control word, 0: the write is a count byte |
| wr_data | input | 8 | Write data byte |
| tick_en | input | 1 | Timer input clock enable |
| irq_o | output | 1 | One-cycle interrupt pulse |
| out_o | output | 1 | Channel output level, low for the period in which the count is 1 |
| count_o | output | 16 | Current count value |

## Verification
On every cycle, the assertions check the following cycle-level properties:
- the interrupt lasts exactly one cycle;
- the interrupt coincides with a count of 1 and a low output;
- the output is low only at a count of 1 and stays low for no more than one tick;
- the count holds steady, and no interrupt appears, without a tick.

Other behaviours depend on what was written earlier, and only the bench's scenarios show them:
- the control word decode, including the words that are ignored;
- the byte toggle reset;
- the low-only and high-only access patterns;
- the restart after a high byte;
- the zero-means-65536 rule;
- the exact 1193-tick period.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  // byte access pattern carried in control word bits [5:4]
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } access_e;
endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              stop_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  access_e           acc_q, acc_n;
  logic              hi_next_q, hi_next_n;
  logic [BYTE_W-1:0] lo_q, lo_n;
  logic              word_ok, mode_ok, ctrl_hit, data_hit;

  always_comb begin
    mode_ok  = (wr_data[3:1] == 3'b010) || (wr_data[3:1] == 3'b110);
    word_ok  = (wr_data[7:6] == CHAN_SEL) && (wr_data[5:4] != 2'b00) &&
               mode_ok && !wr_data[0];
    ctrl_hit = wr_en && wr_ctrl && word_ok;
    data_hit = wr_en && !wr_ctrl;
  end

  always_comb begin
    acc_n      = acc_q;
    hi_next_n  = hi_next_q;
    lo_n       = lo_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (ctrl_hit) begin
      acc_n     = access_e'(wr_data[5:4]);
      hi_next_n = 1'b0;
    end else if (data_hit) begin
      case (acc_q)
        ACC_LO: begin
          load_o     = 1'b1;
          load_val_o = {{BYTE_W{1'b0}}, wr_data};
        end
        ACC_HI: begin
          load_o     = 1'b1;
          load_val_o = {wr_data, {BYTE_W{1'b0}}};
        end
        ACC_LOHI: begin
          if (!hi_next_q) begin
            lo_n      = wr_data;
            hi_next_n = 1'b1;
          end else begin
            load_o     = 1'b1;
            load_val_o = {wr_data, lo_q};
            hi_next_n  = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign stop_o = ctrl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_LOHI;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
    end else begin
      acc_q     <= acc_n;
      hi_next_q <= hi_next_n;
      lo_q      <= lo_n;
    end
  end
endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             out_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_n, rel_q, rel_n;
  logic             run_q, run_n, pend_q, pend_n, irq_q, irq_n;

  always_comb begin
    cnt_n  = cnt_q;
    rel_n  = rel_q;
    run_n  = run_q;
    pend_n = pend_q;
    irq_n  = 1'b0;
    if (stop_i) begin
      run_n  = 1'b0;
      pend_n = 1'b0;
    end else if (load_i) begin
      rel_n  = load_val_i;
      pend_n = 1'b1;
    end else if (tick_i) begin
      if (pend_q) begin
        cnt_n  = rel_q;
        run_n  = 1'b1;
        pend_n = 1'b0;
      end else if (run_q) begin
        if (cnt_q == ONE) begin
          cnt_n = rel_q;
        end else begin
          cnt_n = cnt_q - ONE;
          irq_n = (cnt_q == TWO);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      rel_q  <= rel_n;
      run_q  <= run_n;
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = !(run_q && (cnt_q == ONE));
  assign irq_o = irq_q;
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter logic [1:0] CHAN_SEL = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ctrl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tick_en,
  output logic              irq_o,
  output logic              out_o,
  output logic [CNT_W-1:0]  count_o
);
  logic             stop_w, load_w;
  logic [CNT_W-1:0] load_val_w;

  pit_ctrl_decode #(.CHAN_SEL(CHAN_SEL)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ctrl    (wr_ctrl),
    .wr_data    (wr_data),
    .stop_o     (stop_w),
    .load_o     (load_w),
    .load_val_o (load_val_w)
  );

  pit_down_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_en),
    .stop_i     (stop_w),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .cnt_o      (count_o),
    .out_o      (out_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             tick_en,
  input logic             irq_o,
  input logic             out_o,
  input logic [CNT_W-1:0] count_o
);
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R9
  irq_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (count_o == CNT_W'(1)) && !out_o);
  // R9
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !irq_o);
  // R8
  out_low_at_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_o |-> count_o == CNT_W'(1));
  // R8
  low_one_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_o && tick_en && !wr_en) |=> out_o);
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(count_o));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .tick_en (tick_en),
  .irq_o   (irq_o),
  .out_o   (out_o),
  .count_o (count_o)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_ctrl;
  logic [7:0]  wr_data;
  logic        tick_en;
  logic        irq_o;
  logic        out_o;
  logic [15:0] count_o;

  int errors;
  int checks;
  int cycles;
  bit done;

  localparam int DIV = (1193182 + 500) / 1000;

  pit_channel u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .tick_en (tick_en),
    .irq_o   (irq_o),
    .out_o   (out_o),
    .count_o (count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=190000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit ctrl, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_ctrl = ctrl;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one tick per system cycle; starts and ends at a falling edge
  task automatic ticks(input int n, output int irqs, output int first,
                       output int last);
    irqs = 0;
    first = -1;
    last = -1;
    for (int i = 1; i <= n; i++) begin
      tick_en = 1'b1;
      @(posedge clk);
      #1 tick_en = 1'b0;
      @(negedge clk);
      if (irq_o) begin
        irqs++;
        if (first < 0) first = i;
        last = i;
      end
    end
  endtask

  task automatic t_reset();
    chk(count_o == 16'd0, "R1", "reset count", count_o, 0);
    chk(out_o == 1'b1, "R1", "reset out", out_o, 1);
    chk(irq_o == 1'b0, "R1", "reset irq", irq_o, 0);
  endtask

  task automatic t_basic();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h05);
    ticks(3, n, f, l);
    chk(count_o == 16'd0, "R5", "no start after low byte", count_o, 0);
    chk(n == 0, "R5", "no irq before high byte", n, 0);
    wr(1'b0, 8'h00);
    ticks(1, n, f, l);
    chk(count_o == 16'd5, "R5", "start value", count_o, 5);
    ticks(3, n, f, l);
    chk(count_o == 16'd2, "R7", "decrement per tick", count_o, 2);
    ticks(1, n, f, l);
    chk(n == 1, "R9", "irq at count 1", n, 1);
    chk(out_o == 1'b0, "R8", "out low at 1", out_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b0, "R9", "irq one cycle", irq_o, 0);
    chk(out_o == 1'b0, "R8", "out low until next tick", out_o, 0);
    chk(count_o == 16'd1, "R7", "hold without tick", count_o, 1);
    ticks(1, n, f, l);
    chk(count_o == 16'd5, "R8", "reload value", count_o, 5);
    chk(out_o == 1'b1, "R8", "out high after reload", out_o, 1);
    ticks(10, n, f, l);
    chk(n == 2, "R8", "irqs in 10 ticks", n, 2);
    chk(l - f == 5, "R8", "period", l - f, 5);
  endtask

  task automatic t_divisor();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'(DIV & 255));
    wr(1'b0, 8'(DIV >> 8));
    ticks(1, n, f, l);
    chk(count_o == 16'(DIV), "R11", "loaded divisor", count_o, DIV);
    chk(DIV == 1193, "R11", "divisor value", DIV, 1193);
    ticks(2 * DIV, n, f, l);
    chk(n == 2, "R11", "irqs in two periods", n, 2);
    chk(f == DIV - 1, "R11", "first irq tick", f, DIV - 1);
    chk(l - f == 1193, "R11", "period 1193", l - f, 1193);
  endtask

  task automatic t_toggle();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h03);
    wr(1'b0, 8'h00);
    ticks(1, n, f, l);
    chk(count_o == 16'd3, "R4", "toggle reset by control word", count_o, 3);
  endtask

  task automatic t_stop();
    int n, f, l;
    ticks(1, n, f, l);
    chk(count_o == 16'd2, "R3", "running before stop", count_o, 2);
    wr(1'b1, 8'h34);
    ticks(5, n, f, l);
    chk(count_o == 16'd2, "R3", "count frozen", count_o, 2);
    chk(n == 0, "R3", "no irq when stopped", n, 0);
    chk(out_o == 1'b1, "R3", "out high when stopped", out_o, 1);
  endtask

  task automatic t_ignore();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h08);
    wr(1'b0, 8'h00);
    ticks(1, n, f, l);
    chk(count_o == 16'd8, "R2", "start 8", count_o, 8);
    wr(1'b1, 8'h74);
    ticks(1, n, f, l);
    chk(count_o == 16'd7, "R2", "other channel ignored", count_o, 7);
    wr(1'b1, 8'h35);
    ticks(1, n, f, l);
    chk(count_o == 16'd6, "R2", "BCD word ignored", count_o, 6);
    wr(1'b1, 8'h30);
    ticks(1, n, f, l);
    chk(count_o == 16'd5, "R2", "other mode ignored", count_o, 5);
    wr(1'b1, 8'h04);
    ticks(1, n, f, l);
    chk(count_o == 16'd4, "R2", "access 00 ignored", count_o, 4);
    wr(1'b1, 8'h3C);
    ticks(2, n, f, l);
    chk(count_o == 16'd4, "R2", "mode 110 accepted", count_o, 4);
  endtask

  task automatic t_access();
    int n, f, l;
    wr(1'b1, 8'h14);
    wr(1'b0, 8'h06);
    ticks(1, n, f, l);
    chk(count_o == 16'd6, "R6", "low byte only", count_o, 6);
    wr(1'b1, 8'h24);
    wr(1'b0, 8'h01);
    ticks(1, n, f, l);
    chk(count_o == 16'd256, "R6", "high byte only", count_o, 256);
  endtask

  task automatic t_restart();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h0A);
    wr(1'b0, 8'h00);
    ticks(3, n, f, l);
    chk(count_o == 16'd8, "R5", "running 10", count_o, 8);
    wr(1'b0, 8'h04);
    ticks(1, n, f, l);
    chk(count_o == 16'd7, "R5", "low byte does not restart", count_o, 7);
    wr(1'b0, 8'h00);
    ticks(1, n, f, l);
    chk(count_o == 16'd4, "R5", "restart after high byte", count_o, 4);
  endtask

  task automatic t_zero();
    int n, f, l;
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h00);
    ticks(1, n, f, l);
    chk(count_o == 16'd0, "R10", "zero loaded", count_o, 0);
    ticks(65535, n, f, l);
    chk(n == 1, "R10", "one irq", n, 1);
    chk(f == 65535, "R10", "irq after 65535 ticks", f, 65535);
    ticks(1, n, f, l);
    chk(count_o == 16'd0, "R10", "reload zero", count_o, 0);
    chk(out_o == 1'b1, "R10", "out high after reload", out_o, 1);
  endtask

  initial begin
    errors = 0;
    checks = 0;
    cycles = 0;
    done = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_ctrl = 1'b0;
    wr_data = 8'h00;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_divisor();
    t_toggle();
    t_stop();
    t_ignore();
    t_access();
    t_restart();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule